// File: doc/BRIEF.md
# Tuning Window Phase Selector

This block picks a sampling phase for a delay line after a phase sweep has been run. It takes a 16-bit pass mask in which bit i is set when sampling phase i passed. It looks at the passing phases in groups of consecutive phases. A group that ends at phase 15 and a group that starts at phase 0 count as one window, because the phases form a ring. The block picks the longest window and returns the phase that sits near three quarters of the way into it. If no usable window exists, it reports an error instead.

The mask enters over a valid/ready handshake. The block accepts a mask only when it is idle. While it scans, `in_ready` stays low, and any change on `in_mask` or `in_valid` has no effect. The block walks the mask one phase per clock. It then presents the result on a valid/ready output. The result is held unchanged for as long as `out_ready` is low. When `out_valid` and `out_ready` are high together on a clock edge, the result is released and the block returns to idle. The phase count is a parameter and must be a power of two. It defaults to 16.

Top module: `tphs_top`

## Requirements
- R1: A window is a run of set mask bits with ascending, adjacent phase numbers. The block selects the window with the most phases.
- R2: When two windows have the same length, the one with the lower starting phase is selected.
- R3: When bit 0 is set and a separate run contains phase 15, the two runs form one window. That window starts at the first phase of the run holding phase 15, passes through phase 15 and phase 0, and continues upward.
- R4: For the length comparison, a joined wrap window is ranked at the place of the run that holds phase 15. A run that starts earlier and has equal length therefore wins.
- R5: Let L be the length of the selected window. The offset is floor(3L/4), minus one if that value is nonzero. `out_phase` is (window start + offset) mod 16, as an unsigned binary number.
- R6: An all-zero mask gives `out_err`=1 with `out_phase`=0. A joined wrap window of 16 or more phases also gives this error.
- R7: A mask with all 16 bits set forms one window of length 16 and gives phase 11.
- R8: `in_ready` is high only while idle. A mask is taken on a clock edge where `in_valid` and `in_ready` are both high. Input activity while busy has no effect on the result.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_phase` and `out_err` stay stable. After the transfer edge, `out_valid` is low and `in_ready` is high.
- R10: `out_valid` rises exactly 17 clock edges after the edge that accepted the mask.
- R11: During reset and after it, `in_ready`=1 and `out_valid`=0. A reset in the middle of a scan abandons that scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Mask offered |
| in_ready | output | 1 | Block idle, mask can be taken |
| in_mask | input | 16 | Pass mask, bit i is phase i |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_phase | output | 4 | Selected phase |
| out_err | output | 1 | No usable window |

## Verification
The bound checker checks the handshake on every cycle:
- `in_ready` and `out_valid` are never high together.
- A mask, once taken, stops further acceptance.
- A result held under back-pressure stays stable, and a transfer releases it.
- The result appears 17 edges after acceptance.
- An error result always carries phase 0.

The choice of window cannot be checked cycle by cycle. This covers ring joining, tie order, the rank of a joined window, the three-quarter offset with its wrap past phase 15, and the all-pass and empty masks. Only the bench's mask vectors, whose expected phases were worked out by hand, can show these behaviours.

// File: rtl/tphs_pkg.sv
package tphs_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_SCAN = 2'd1,
    S_DONE = 2'd2,
    S_HOLD = 2'd3
  } tphs_state_e;
endpackage

// File: rtl/tphs_scan.sv
// Walks the mask one phase per step and keeps run statistics:
// the first closed run, the longest later closed run, and the open run.
module tphs_scan #(
  parameter int NPH = 16,
  localparam int PW = $clog2(NPH),
  localparam int LW = $clog2(NPH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic          bit_in,
  input  logic [PW-1:0] idx,
  output logic          first_done,
  output logic [PW-1:0] first_start,
  output logic [LW-1:0] first_len,
  output logic [PW-1:0] mid_start,
  output logic [LW-1:0] mid_len,
  output logic [PW-1:0] cur_start,
  output logic [LW-1:0] cur_len
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_done  <= 1'b0;
      first_start <= '0;
      first_len   <= '0;
      mid_start   <= '0;
      mid_len     <= '0;
      cur_start   <= '0;
      cur_len     <= '0;
    end else if (clr) begin
      first_done  <= 1'b0;
      first_start <= '0;
      first_len   <= '0;
      mid_start   <= '0;
      mid_len     <= '0;
      cur_start   <= '0;
      cur_len     <= '0;
    end else if (step) begin
      if (bit_in) begin
        if (cur_len == '0) begin
          cur_start <= idx;
          cur_len   <= LW'(1);
        end else begin
          cur_len <= cur_len + LW'(1);
        end
      end else if (cur_len != '0) begin
        // run closes here
        if (!first_done) begin
          first_done  <= 1'b1;
          first_start <= cur_start;
          first_len   <= cur_len;
        end else if (cur_len > mid_len) begin
          mid_start <= cur_start;
          mid_len   <= cur_len;
        end
        cur_len <= '0;
      end
    end
  end
endmodule

// File: rtl/tphs_pick.sv
// Combinational resolve: ring join, ordered longest pick, offset.
module tphs_pick #(
  parameter int NPH = 16,
  localparam int PW = $clog2(NPH),
  localparam int LW = $clog2(NPH + 1),
  localparam int SW = LW + 1
) (
  input  logic          first_done,
  input  logic [PW-1:0] first_start,
  input  logic [LW-1:0] first_len,
  input  logic [PW-1:0] mid_start,
  input  logic [LW-1:0] mid_len,
  input  logic [PW-1:0] cur_start,
  input  logic [LW-1:0] cur_len,
  output logic [PW-1:0] phase,
  output logic          err
);
  logic          join_ring;
  logic [SW-1:0] tail_len;
  logic [SW-1:0] best_len;
  logic [PW-1:0] best_start;
  logic [SW+1:0] off3;
  logic [SW+1:0] off;

  always_comb begin
    join_ring = (cur_len != '0) && first_done && (first_start == '0);
    tail_len  = join_ring ? (SW'(cur_len) + SW'(first_len)) : SW'(cur_len);

    best_len   = '0;
    best_start = '0;
    if (first_done && !join_ring) begin
      best_len   = SW'(first_len);
      best_start = first_start;
    end
    if (SW'(mid_len) > best_len) begin
      best_len   = SW'(mid_len);
      best_start = mid_start;
    end
    if (tail_len > best_len) begin
      best_len   = tail_len;
      best_start = cur_start;
    end

    err  = (best_len == '0) || (join_ring && (tail_len >= SW'(NPH)));
    off3 = ((SW+2)'(best_len) * (SW+2)'(3)) >> 2;
    off  = (off3 != '0) ? off3 - (SW+2)'(1) : off3;
    phase = err ? '0 : best_start + off[PW-1:0];
  end
endmodule

// File: rtl/tphs_top.sv
module tphs_top #(
  parameter int NPH = 16,
  localparam int PW = $clog2(NPH),
  localparam int LW = $clog2(NPH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [NPH-1:0] in_mask,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [PW-1:0]  out_phase,
  output logic           out_err
);
  import tphs_pkg::*;

  tphs_state_e    state_q;
  logic [PW-1:0]  idx_q;
  logic [NPH-1:0] mask_q;
  logic [PW-1:0]  phase_q;
  logic           err_q;
  logic           accept;

  logic          first_done;
  logic [PW-1:0] first_start, mid_start, cur_start;
  logic [LW-1:0] first_len, mid_len, cur_len;
  logic [PW-1:0] pick_phase;
  logic          pick_err;

  assign in_ready  = (state_q == S_IDLE);
  assign accept    = in_valid && in_ready;
  assign out_valid = (state_q == S_HOLD);
  assign out_phase = phase_q;
  assign out_err   = err_q;

  tphs_scan #(.NPH(NPH)) u_scan (
    .clk(clk), .rst_n(rst_n), .clr(accept),
    .step(state_q == S_SCAN), .bit_in(mask_q[idx_q]), .idx(idx_q),
    .first_done(first_done), .first_start(first_start), .first_len(first_len),
    .mid_start(mid_start), .mid_len(mid_len),
    .cur_start(cur_start), .cur_len(cur_len)
  );

  tphs_pick #(.NPH(NPH)) u_pick (
    .first_done(first_done), .first_start(first_start), .first_len(first_len),
    .mid_start(mid_start), .mid_len(mid_len),
    .cur_start(cur_start), .cur_len(cur_len),
    .phase(pick_phase), .err(pick_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      mask_q  <= '0;
      phase_q <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          mask_q  <= in_mask;
          idx_q   <= '0;
          state_q <= S_SCAN;
        end
        S_SCAN: begin
          idx_q <= idx_q + PW'(1);
          if (idx_q == PW'(NPH - 1)) state_q <= S_DONE;
        end
        S_DONE: begin
          phase_q <= pick_phase;
          err_q   <= pick_err;
          state_q <= S_HOLD;
        end
        default: if (out_ready) state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tphs_chk.sv
module tphs_chk #(
  parameter int NPH = 16,
  localparam int PW = $clog2(NPH),
  localparam int LAT = NPH + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [PW-1:0] out_phase,
  input logic          out_err
);
  logic [7:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_cnt <= '0;
    else if (in_valid && in_ready) lat_cnt <= '0;
    else if (!in_ready && !out_valid && lat_cnt != 8'hff) lat_cnt <= lat_cnt + 8'd1;
  end

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_phase) && $stable(out_err)));
  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));
  p_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_cnt == 8'(LAT)));
  p_errz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_phase == '0));
endmodule

bind tphs_top tphs_chk #(.NPH(NPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_phase(out_phase), .out_err(out_err)
);

// File: tb/sim_tphs_top.sv
`timescale 1ns/1ps
module sim_tphs_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_mask = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [3:0]  out_phase;
  logic        out_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tphs_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mask(in_mask), .out_valid(out_valid), .out_ready(out_ready),
    .out_phase(out_phase), .out_err(out_err)
  );

  // {mask, expected phase, expected error}
  localparam int NV = 16;
  localparam logic [20:0] VEC [NV] = '{
    {16'h0000, 4'd0,  1'b1},  // R6 empty
    {16'hFFFF, 4'd11, 1'b0},  // R7 all pass
    {16'h0001, 4'd0,  1'b0},  // R5 len 1
    {16'h8000, 4'd15, 1'b0},  // R1 lone top phase
    {16'h8001, 4'd15, 1'b0},  // R3 join 15+0
    {16'hC007, 4'd0,  1'b0},  // R3 R5 offset wraps
    {16'h00F0, 4'd6,  1'b0},  // R5 len 4
    {16'h0E0E, 4'd2,  1'b0},  // R2 tie
    {16'h3F03, 4'd11, 1'b0},  // R1 later longer
    {16'h8061, 4'd5,  1'b0},  // R4 joined ranked late
    {16'hE073, 4'd15, 1'b0},  // R3 joined longest
    {16'h5555, 4'd0,  1'b0},  // R2 many singles
    {16'hAAAA, 4'd1,  1'b0},  // R1 no join without 0
    {16'h7FFE, 4'd10, 1'b0},  // R5 len 14
    {16'hFFFE, 4'd11, 1'b0},  // R1 one run to 15
    {16'hFFF7, 4'd14, 1'b0}   // R3 len 15 joined
  };

  function automatic string vtag(input int i);
    case (i)
      0: return "R6";
      1: return "R7";
      2, 6, 13: return "R5";
      4, 5, 10, 15: return "R3";
      7, 11: return "R2";
      9: return "R4";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_mask(input logic [15:0] m, input logic [3:0] eph,
                          input logic eerr, input string req, input int hold);
    int n;
    logic [3:0] ph0;
    @(negedge clk);
    in_mask = m;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_mask = ~m;          // R8 ignored while busy
    n = 0;
    while (!out_valid && n < 100) begin
      @(negedge clk);
      n++;
      if (n == 3) check(!in_ready, "R8 busy", in_ready, 0);
    end
    in_valid = 1'b0;
    check(n == 17, "R10 latency", n, 17);
    check(out_phase == eph, req, out_phase, eph);
    check(out_err == eerr, req, out_err, eerr);
    ph0 = out_phase;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(out_valid && out_phase == ph0, "R9 hold", out_phase, ph0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R9 release", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready && !out_valid, "R11 in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !out_valid, "R11 after reset", in_ready, 1);

    for (int i = 0; i < NV; i++)
      run_mask(VEC[i][20:5], VEC[i][4:1], VEC[i][0], vtag(i), 0);

    // R9 back-pressure hold
    run_mask(16'h00F0, 4'd6, 1'b0, "R9", 4);

    // R11 reset in mid scan
    @(negedge clk);
    in_mask = 16'h00F0;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(in_ready && !out_valid, "R11 abandoned scan", out_valid, 0);

    // follow-up run still right after the abandoned scan
    run_mask(16'h0E0E, 4'd2, 1'b0, "R2", 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule